// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one addressing-mode request of an 8-bit processor into a 16-bit effective address. A request gives a mode code, up to two operand bytes (low byte first, then high byte), the two index registers and the program counter. Modes that need no pointer are resolved in a single cycle. The three indirect modes first read a two-byte pointer from memory over a byte-wide request/acknowledge port. A `done` strobe marks the cycle in which `eff_addr` and `page_crossed` hold the result, and both then keep that value until the next result.

`page_crossed` reports that an add carried into the high byte, or that a branch target lies on a different page than the program counter. Timing logic elsewhere uses this flag. The flag is only produced by the modes that add an index or offset with carry: absolute indexed, post-indexed indirect and relative. Zero-page indexing and zero-page pointer reads wrap inside page zero and never report a crossing.

The pointer reader is a three-state machine. `F_IDLE` waits for a fetched-mode request and moves to `F_PTR_LO`. `F_PTR_LO` holds the read of the pointer's low byte until it is acknowledged, then moves to `F_PTR_HI`. `F_PTR_HI` holds the read of the high byte until it is acknowledged, then returns to `F_IDLE` and the result is registered.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `rd_req` and `page_crossed` are low and `eff_addr` is zero.
- R2: Mode code 0 (immediate, implied or accumulator operands) and the unused codes 11 to 15 produce `done` with `eff_addr` zero and `page_crossed` low, without any read.
- R3: Mode code 1 (zero page) gives `{8'h00, op_lo}`.
- R4: Mode codes 2 (zero page + X) and 3 (zero page + Y) give a high byte of zero and a low byte of `(op_lo + index) mod 256`. `page_crossed` stays low.
- R5: Mode code 4 (absolute) gives `{op_hi, op_lo}` with `page_crossed` low.
- R6: Mode codes 5 (absolute + X) and 6 (absolute + Y) give the 16-bit sum `{op_hi, op_lo} + index`, wrapping at 16 bits. `page_crossed` is high exactly when the result's high byte differs from `op_hi`.
- R7: Mode code 10 (relative) gives `pc` plus `op_lo` read as a signed two's-complement offset (-128 to +127). The `pc` input is used as given. `page_crossed` is high exactly when the target's high byte differs from `pc[15:8]`.
- R8: Mode code 7 (pre-indexed indirect) reads address `{8'h00, op_lo+idx_x}` and then `{8'h00, op_lo+idx_x+1}`, both low bytes taken mod 256. The result is `{second byte, first byte}` with `page_crossed` low.
- R9: Mode code 8 (post-indexed indirect) reads `{8'h00, op_lo}` and then `{8'h00, op_lo+1 mod 256}`. The result is that pointer plus `idx_y` with a 16-bit carry. `page_crossed` is high when the high byte changes.
- R10: Mode code 9 (absolute indirect) reads `{op_hi, op_lo}` and then that address plus 1 with a full 16-bit carry. The result is the word read, with `page_crossed` low.
- R11: A read keeps `rd_req` high and `rd_addr` unchanged until it is acknowledged, and each pointer byte is read exactly once. `done` comes 1 cycle after an accepted direct request. For a fetched mode, `done` comes 1 cycle after the second acknowledge. `rd_req` is low whenever `done` is high.
- R12: `start` is ignored while `rd_req` is high: it produces no extra result and does not change the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 4 | Addressing-mode code (see requirements) |
| op_lo | input | 8 | First operand byte (low address byte or offset) |
| op_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Program counter for relative mode |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid with `rd_ack` |
| rd_ack | input | 1 | Read acknowledge |
| done | output | 1 | Result strobe |
| eff_addr | output | 16 | Effective address |
| page_crossed | output | 1 | High byte changed by the add |

## Verification
A direct mode's result is due 1 cycle after the edge that samples `start`. A fetched mode's result is due `3 + 2*D` cycles after that edge when memory holds each read for `D` cycles before acknowledging. The driver stamps each expected item with the cycle in which it raised `start`. The monitor compares that stamp with the cycle in which `done` appears, so a result that comes early or late fails just as a wrong address does. The memory responder checks every pointer address against its own queue of expected reads, and it is run with several acknowledge delays.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        EA_NONE    = 4'd0,
        EA_ZP      = 4'd1,
        EA_ZPX     = 4'd2,
        EA_ZPY     = 4'd3,
        EA_ABS     = 4'd4,
        EA_ABSX    = 4'd5,
        EA_ABSY    = 4'd6,
        EA_PREIDX  = 4'd7,
        EA_POSTIDX = 4'd8,
        EA_INDIR   = 4'd9,
        EA_REL     = 4'd10
    } ea_mode_e;

    typedef enum logic [1:0] {
        F_IDLE   = 2'd0,
        F_PTR_LO = 2'd1,
        F_PTR_HI = 2'd2
    } fetch_state_e;

    function automatic logic in_page0(input ea_mode_e m);
        return (m == EA_ZP) || (m == EA_ZPX) || (m == EA_ZPY);
    endfunction

    function automatic logic never_crosses(input ea_mode_e m);
        return (m == EA_NONE) || in_page0(m) || (m == EA_ABS) ||
               (m == EA_PREIDX) || (m == EA_INDIR);
    endfunction

endpackage

// File: rtl/ea_offset_add.sv
module ea_offset_add #(
    parameter int BYTE_W     = 8,
    parameter bit SIGNED_OFF = 1'b0,
    localparam int ADDR_W    = 2 * BYTE_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BYTE_W-1:0] off,
    output logic [ADDR_W-1:0] sum,
    output logic              crossed
);
    logic [ADDR_W-1:0] off_ext;

    generate
        if (SIGNED_OFF) begin : g_sext
            assign off_ext = {{BYTE_W{off[BYTE_W-1]}}, off};
        end else begin : g_zext
            assign off_ext = {{BYTE_W{1'b0}}, off};
        end
    endgenerate

    assign sum     = base + off_ext;
    assign crossed = sum[ADDR_W-1:BYTE_W] != base[ADDR_W-1:BYTE_W];
endmodule

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
    import ea_pkg::*;
#(
    parameter int BYTE_W  = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  ea_mode_e          mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [BYTE_W-1:0] idx_x,
    input  logic [BYTE_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] direct_addr,
    output logic              direct_cross,
    output logic              needs_fetch,
    output logic [ADDR_W-1:0] ptr_base,
    output logic              ptr_zp_wrap
);
    localparam logic [BYTE_W-1:0] PAGE0 = '0;

    logic [BYTE_W-1:0] abs_idx;
    logic [ADDR_W-1:0] abs_sum;
    logic              abs_cross;
    logic [ADDR_W-1:0] rel_sum;
    logic              rel_cross;
    logic [BYTE_W-1:0] zpx_lo;
    logic [BYTE_W-1:0] zpy_lo;

    assign abs_idx = (mode == EA_ABSY) ? idx_y : idx_x;
    assign zpx_lo  = op_lo + idx_x;
    assign zpy_lo  = op_lo + idx_y;

    ea_offset_add #(.BYTE_W(BYTE_W), .SIGNED_OFF(1'b0)) u_abs_add (
        .base    ({op_hi, op_lo}),
        .off     (abs_idx),
        .sum     (abs_sum),
        .crossed (abs_cross)
    );

    ea_offset_add #(.BYTE_W(BYTE_W), .SIGNED_OFF(1'b1)) u_rel_add (
        .base    (pc),
        .off     (op_lo),
        .sum     (rel_sum),
        .crossed (rel_cross)
    );

    always_comb begin
        direct_addr  = '0;
        direct_cross = 1'b0;
        needs_fetch  = 1'b0;
        ptr_base     = '0;
        ptr_zp_wrap  = 1'b0;
        unique case (mode)
            EA_ZP:      direct_addr = {PAGE0, op_lo};
            EA_ZPX:     direct_addr = {PAGE0, zpx_lo};
            EA_ZPY:     direct_addr = {PAGE0, zpy_lo};
            EA_ABS:     direct_addr = {op_hi, op_lo};
            EA_ABSX, EA_ABSY: begin
                direct_addr  = abs_sum;
                direct_cross = abs_cross;
            end
            EA_REL: begin
                direct_addr  = rel_sum;
                direct_cross = rel_cross;
            end
            EA_PREIDX: begin
                needs_fetch = 1'b1;
                ptr_base    = {PAGE0, zpx_lo};
                ptr_zp_wrap = 1'b1;
            end
            EA_POSTIDX: begin
                needs_fetch = 1'b1;
                ptr_base    = {PAGE0, op_lo};
                ptr_zp_wrap = 1'b1;
            end
            EA_INDIR: begin
                needs_fetch = 1'b1;
                ptr_base    = {op_hi, op_lo};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
    import ea_pkg::*;
#(
    parameter int BYTE_W  = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic              zp_wrap,
    output logic              busy,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_ack,
    output logic              word_valid,
    output logic [ADDR_W-1:0] word
);
    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] lo_q;
    logic              wrap_q;
    logic [BYTE_W-1:0] lo_next;

    assign lo_next = addr_q[BYTE_W-1:0] + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE:   if (go)     state_d = F_PTR_LO;
            F_PTR_LO: if (rd_ack) state_d = F_PTR_HI;
            F_PTR_HI: if (rd_ack) state_d = F_IDLE;
            default:              state_d = F_IDLE;
        endcase
    end

    // address and low byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            lo_q   <= '0;
            wrap_q <= 1'b0;
        end else if (state_q == F_IDLE && go) begin
            addr_q <= ptr_base;
            wrap_q <= zp_wrap;
        end else if (state_q == F_PTR_LO && rd_ack) begin
            lo_q   <= rd_data;
            addr_q <= wrap_q ? {addr_q[ADDR_W-1:BYTE_W], lo_next} : addr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = state_q != F_IDLE;
        rd_req     = busy;
        rd_addr    = addr_q;
        word_valid = (state_q == F_PTR_HI) && rd_ack;
        word       = {rd_data, lo_q};
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R8 and R9: zero-page pointer reads never leave page zero
    p_zp_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && wrap_q |-> rd_addr[ADDR_W-1:BYTE_W] == '0);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int BYTE_W  = 8,
    localparam int ADDR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [BYTE_W-1:0] idx_x,
    input  logic [BYTE_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_ack,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              page_crossed
);
    ea_mode_e          mode_in, mode_q;
    logic [BYTE_W-1:0] y_q;
    logic [ADDR_W-1:0] direct_addr, ptr_base, word, post_sum;
    logic              direct_cross, needs_fetch, ptr_zp_wrap;
    logic              busy, word_valid, post_cross, accept;
    logic              done_q, cross_q;
    logic [ADDR_W-1:0] eff_q;

    assign mode_in = ea_mode_e'(mode);
    assign accept  = start && !busy;

    ea_direct_calc #(.BYTE_W(BYTE_W)) u_direct (
        .mode         (mode_in),
        .op_lo        (op_lo),
        .op_hi        (op_hi),
        .idx_x        (idx_x),
        .idx_y        (idx_y),
        .pc           (pc),
        .direct_addr  (direct_addr),
        .direct_cross (direct_cross),
        .needs_fetch  (needs_fetch),
        .ptr_base     (ptr_base),
        .ptr_zp_wrap  (ptr_zp_wrap)
    );

    ea_ptr_fetch #(.BYTE_W(BYTE_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (accept && needs_fetch),
        .ptr_base   (ptr_base),
        .zp_wrap    (ptr_zp_wrap),
        .busy       (busy),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rd_ack     (rd_ack),
        .word_valid (word_valid),
        .word       (word)
    );

    ea_offset_add #(.BYTE_W(BYTE_W), .SIGNED_OFF(1'b0)) u_post_add (
        .base    (word),
        .off     (y_q),
        .sum     (post_sum),
        .crossed (post_cross)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= EA_NONE;
            y_q     <= '0;
            done_q  <= 1'b0;
            eff_q   <= '0;
            cross_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= mode_in;
                y_q    <= idx_y;
                if (!needs_fetch) begin
                    done_q  <= 1'b1;
                    eff_q   <= direct_addr;
                    cross_q <= direct_cross;
                end
            end
            if (word_valid) begin
                done_q <= 1'b1;
                if (mode_q == EA_POSTIDX) begin
                    eff_q   <= post_sum;
                    cross_q <= post_cross;
                end else begin
                    eff_q   <= word;
                    cross_q <= 1'b0;
                end
            end
        end
    end

    assign done         = done_q;
    assign eff_addr     = eff_q;
    assign page_crossed = cross_q;

    p_no_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_q == EA_NONE |-> eff_addr == '0 && !page_crossed);

    p_page0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && in_page0(mode_q) |-> eff_addr[ADDR_W-1:BYTE_W] == '0);

    // R5, R8 and R10: these modes never report a crossing
    p_flat_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && never_crosses(mode_q) |-> !page_crossed);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && start |=> $stable(mode_q) && $stable(y_q));
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
    logic [15:0] pc = '0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        rd_ack = 1'b0;
    logic        done;
    logic [15:0] eff_addr;
    logic        page_crossed;

    always #10 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack),
        .done(done), .eff_addr(eff_addr), .page_crossed(page_crossed)
    );

    typedef struct {
        logic [15:0] ea;
        logic        cx;
        int          lat;
        int          stamp;
        int          req;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] rdq[$];
    int cyc = 0, checks = 0, fails = 0;
    int ack_delay = 0, wait_cnt = 0, cur_req = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] byte_at(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // monitor: pops expected results as done appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, 12, "unexpected done", {16'h0, eff_addr}, 32'h0); // R12
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(eff_addr == it.ea, it.req, "eff_addr", {16'h0, eff_addr}, {16'h0, it.ea});
                check(page_crossed == it.cx, it.req, "page_crossed",
                      {31'h0, page_crossed}, {31'h0, it.cx});
                check(cyc - it.stamp == it.lat, 11, "latency", cyc - it.stamp, it.lat); // R11
                check(!rd_req, 11, "rd_req during done", {31'h0, rd_req}, 32'h0);     // R11
            end
        end
    end

    // memory responder with programmable acknowledge delay
    always @(negedge clk) begin
        rd_ack = 1'b0;
        if (rst_n && rd_req) begin
            if (wait_cnt >= ack_delay) begin
                if (rdq.size() == 0) begin
                    check(1'b0, 11, "unexpected read", {16'h0, rd_addr}, 32'h0); // R11
                end else begin
                    logic [15:0] ea;
                    ea = rdq.pop_front();
                    check(rd_addr == ea, cur_req, "rd_addr", {16'h0, rd_addr}, {16'h0, ea});
                end
                rd_data  = byte_at(rd_addr);
                rd_ack   = 1'b1;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] pcv,
                         input int d, input int req, input bit disturb);
        exp_t        it;
        logic [15:0] p0, p1, w;
        bit          fetch = 1'b0;
        int          t = 0;
        it.ea = '0; it.cx = 1'b0; it.lat = 1; it.req = req;
        p0 = '0; p1 = '0;
        case (m)
            4'd1: it.ea = {8'h00, lo};
            4'd2: it.ea = {8'h00, 8'(lo + x)};
            4'd3: it.ea = {8'h00, 8'(lo + y)};
            4'd4: it.ea = {hi, lo};
            4'd5: begin it.ea = {hi, lo} + {8'h00, x}; it.cx = it.ea[15:8] != hi; end
            4'd6: begin it.ea = {hi, lo} + {8'h00, y}; it.cx = it.ea[15:8] != hi; end
            4'd7: begin fetch = 1'b1; p0 = {8'h00, 8'(lo + x)}; p1 = {8'h00, 8'(lo + x + 8'd1)}; end
            4'd8: begin fetch = 1'b1; p0 = {8'h00, lo}; p1 = {8'h00, 8'(lo + 8'd1)}; end
            4'd9: begin fetch = 1'b1; p0 = {hi, lo}; p1 = {hi, lo} + 16'd1; end
            4'd10: begin
                it.ea = pcv + {{8{lo[7]}}, lo};
                it.cx = it.ea[15:8] != pcv[15:8];
            end
            default: ;
        endcase
        if (fetch) begin
            w      = {byte_at(p1), byte_at(p0)};
            it.ea  = (m == 4'd8) ? w + {8'h00, y} : w;
            it.cx  = (m == 4'd8) && (it.ea[15:8] != w[15:8]);
            it.lat = 3 + 2 * d;
            rdq.push_back(p0);
            rdq.push_back(p1);
        end
        ack_delay = d;
        cur_req   = req;
        @(negedge clk);
        mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc = pcv;
        start = 1'b1;
        it.stamp = cyc;
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R12: a second request while the pointer read is outstanding
            mode = 4'd4; op_lo = ~lo; op_hi = 8'hEE; idx_y = ~y;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0 && t < 200) begin
            @(negedge clk);
            t++;
        end
        if (t >= 200) check(1'b0, 11, "result timeout", t, 0); // R11
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, 11, "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, 1, "done in reset", {31'h0, done}, 32'h0);
        check(rd_req == 1'b0, 1, "rd_req in reset", {31'h0, rd_req}, 32'h0);
        check(eff_addr == 16'h0, 1, "eff_addr in reset", {16'h0, eff_addr}, 32'h0);
        check(page_crossed == 1'b0, 1, "page_crossed in reset", {31'h0, page_crossed}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(4'd0,  8'h12, 8'h34, 8'h01, 8'h02, 16'h1234, 0, 2, 1'b0); // R2
        issue(4'd13, 8'h55, 8'h66, 8'h01, 8'h02, 16'h4321, 0, 2, 1'b0); // R2 unused code
        issue(4'd1,  8'h7E, 8'hAB, 8'h00, 8'h00, 16'h0,    0, 3, 1'b0); // R3
        issue(4'd2,  8'hF0, 8'hAB, 8'h20, 8'h00, 16'h0,    0, 4, 1'b0); // R4 wraps to 0010
        issue(4'd3,  8'h05, 8'hAB, 8'h99, 8'h03, 16'h0,    0, 4, 1'b0); // R4
        issue(4'd4,  8'h34, 8'h12, 8'h00, 8'h00, 16'h0,    0, 5, 1'b0); // R5
        issue(4'd5,  8'hF0, 8'h12, 8'h20, 8'h00, 16'h0,    0, 6, 1'b0); // R6 crosses
        issue(4'd6,  8'h00, 8'h12, 8'hFF, 8'h05, 16'h0,    0, 6, 1'b0); // R6 same page
        issue(4'd5,  8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0,    0, 6, 1'b0); // R6 16-bit wrap
        issue(4'd10, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1280, 0, 7, 1'b0); // R7 -128 same page
        issue(4'd10, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1205, 0, 7, 1'b0); // R7 back across
        issue(4'd10, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h12F0, 0, 7, 1'b0); // R7 forward across
        issue(4'd10, 8'h05, 8'h00, 8'h00, 8'h00, 16'h1210, 0, 7, 1'b0); // R7
        issue(4'd7,  8'hF0, 8'h55, 8'h0F, 8'h00, 16'h0,    0, 8, 1'b0); // R8 pointer wraps
        issue(4'd7,  8'h10, 8'h55, 8'h22, 8'h00, 16'h0,    2, 8, 1'b0); // R8 slow memory
        issue(4'd8,  8'hFF, 8'h55, 8'h00, 8'hF0, 16'h0,    1, 9, 1'b0); // R9 pointer wraps
        issue(4'd8,  8'h40, 8'h55, 8'h00, 8'h00, 16'h0,    0, 9, 1'b0); // R9 zero index
        issue(4'd8,  8'h81, 8'h55, 8'h00, 8'hC7, 16'h0,    3, 9, 1'b0); // R9
        issue(4'd9,  8'hFF, 8'h30, 8'h00, 8'h00, 16'h0,    0, 10, 1'b0); // R10 carry into high
        issue(4'd9,  8'h20, 8'hA0, 8'h00, 8'h00, 16'h0,    1, 10, 1'b0); // R10
        issue(4'd8,  8'h90, 8'h00, 8'h00, 8'hE5, 16'h0,    2, 12, 1'b1); // R12 start ignored
        issue(4'd7,  8'h33, 8'h00, 8'h44, 8'h00, 16'h0,    0, 12, 1'b1); // R12

        check(rdq.size() == 0, 11, "reads left over", rdq.size(), 0); // R11
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule